// File: doc/BRIEF.md
# Priority Bus Arbitration Point

This block decides which of sixteen channel requesters owns a shared bus. Each requester drives one bit of `req`; the bit index is its level, and a lower level wins. Level 15 belongs to the host processor. Two internal sources sit above every channel level: memory refresh, which always wins, and NMI, which is next. These two are served without ever leaving the arbitrate state. A channel owner keeps its grant until it signals the end of its transfer. While it holds the grant, the block raises a preempt line whenever a more urgent source is waiting.

Each arbitrate phase lasts a minimum time. That time is given in nanoseconds and converted to clock cycles. A control bit doubles it. A single 8-bit control/status register sets the arbitration behaviour. When written, its bits enable host cycles during arbitration, force the bus to stay in arbitrate, and select the longer arbitration time. When read, its bits report host-cycle enable, NMI masking, a bus time-out, and the level that held the most recent channel grant. A grant that runs past a cycle limit is ended, and the time-out is recorded.

Top module: `prio_bus_arbiter`

## Requirements
- R1: At the end of an arbitrate phase, the lowest set bit index of `req` receives the channel grant: `grant_valid`=1, `grant_level`=that index, `arb_state`=0.
- R2: A pending refresh request wins over NMI and over all channel levels. A pending NMI wins over all channel levels. Refresh and NMI are served with `arb_state` held at 1 and flagged on `grant_refresh` / `grant_nmi`. A refresh service ends on `xfer_done`.
- R3: An arbitrate phase lasts ceil(ARB_MIN_NS/CLK_PERIOD_NS) cycles, which is 3 by default. When write bit 5 is 1, it lasts ceil(ARB_EXT_NS/CLK_PERIOD_NS) cycles, which is 6 by default. With no request pending, the block stays in arbitrate.
- R4: An NMI service holds `arb_state`=1 and `grant_nmi`=1 for as long as `nmi_req` stays high. It returns to arbitrate one cycle after `nmi_req` falls. Entering NMI service sets read bit 6.
- R5: `preempt` is 1 only during a channel grant, and only while refresh, NMI or a lower level than `grant_level` is requesting. A channel grant ends on `xfer_done`.
- R6: Write bit 6 set to 1 keeps the block in arbitrate with no channel grant. Write bit 7 drives `cpu_cyc_en` and reads back on bit 7.
- R7: A channel grant that lasts TIMEOUT_CYC cycles without `xfer_done` is ended and sets read bit 5. A read (`reg_rd`) with bit 5 set clears bits 5 and 6. A read with bit 5 clear leaves bit 6 as it is.
- R8: Read bits 3:0 hold the level captured at the start of the most recent channel grant, and bit 4 reads 0. After reset the read value is 0x00, `arb_state`=1 and there is no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 16 | Channel requests, bit index = level |
| refresh_req | input | 1 | Memory refresh request |
| nmi_req | input | 1 | NMI request, held until serviced |
| xfer_done | input | 1 | Current owner ends its transfer |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Status register read strobe |
| reg_wdata | input | 8 | Control write data |
| reg_rdata | output | 8 | Status read data |
| arb_state | output | 1 | 1 = arbitrate, 0 = channel grant |
| grant_valid | output | 1 | A channel level holds the bus |
| grant_level | output | 4 | Level of the channel owner |
| grant_refresh | output | 1 | Refresh being served |
| grant_nmi | output | 1 | NMI being served |
| preempt | output | 1 | Owner should release the bus |
| cpu_cyc_en | output | 1 | Host cycles allowed during arbitration |

## Verification
The bench keeps the default timing values, 100 ns clock units with 300/600 ns arbitration. These give 3- and 6-cycle arbitrate phases, so the bench can probe both edges of each phase exactly. It builds the block with TIMEOUT_CYC=12, so a stalled grant times out in a dozen cycles. That puts the time-out bit, and its interaction with the NMI mask bit on read, within a short run.

// File: rtl/pba_pkg.sv
package pba_pkg;

    localparam int NUM_LVL = 16;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int DATA_W  = 8;

    typedef enum logic [1:0] {
        ST_ARB     = 2'd0,
        ST_REFRESH = 2'd1,
        ST_NMI     = 2'd2,
        ST_GRANT   = 2'd3
    } pba_state_e;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
    } pick_t;

    typedef struct packed {
        logic cpu_en;
        logic force_arb;
        logic ext_arb;
    } cfg_t;

    // Mask of all levels strictly more urgent than lvl
    function automatic logic [NUM_LVL-1:0] below_mask(input logic [LVL_W-1:0] lvl);
        logic [NUM_LVL-1:0] m;
        for (int i = 0; i < NUM_LVL; i++) begin
            m[i] = (i < int'(lvl));
        end
        return m;
    endfunction

endpackage

// File: rtl/pba_resolve.sv
module pba_resolve
    import pba_pkg::*;
(
    input  logic [NUM_LVL-1:0] req,
    output pick_t              pick
);
    // Scan from the least urgent level down so the lowest index is kept
    always_comb begin
        pick = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.valid = 1'b1;
                pick.level = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/pba_cfg.sv
module pba_cfg
    import pba_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_to,
    input  logic              set_nmi_mask,
    input  logic              cap_en,
    input  logic [LVL_W-1:0]  cap_level,
    output cfg_t              cfg,
    output logic [DATA_W-1:0] rdata
);
    logic             to_flag;
    logic             nmi_mask;
    logic [LVL_W-1:0] last_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            to_flag  <= 1'b0;
            nmi_mask <= 1'b0;
            last_lvl <= '0;
        end else begin
            if (wr) begin
                cfg.cpu_en    <= wdata[7];
                cfg.force_arb <= wdata[6];
                cfg.ext_arb   <= wdata[5];
            end
            if (cap_en)
                last_lvl <= cap_level;
            if (set_to)
                to_flag <= 1'b1;
            else if (rd)
                to_flag <= 1'b0;
            if (set_nmi_mask)
                nmi_mask <= 1'b1;
            else if (rd && to_flag)
                nmi_mask <= 1'b0;
        end
    end

    assign rdata = {cfg.cpu_en, nmi_mask, to_flag, 1'b0, last_lvl};

    // R7: time-out bit survives until a read clears it
    p_timeout_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (to_flag && !rd) |=> to_flag);

endmodule

// File: rtl/pba_seq.sv
module pba_seq
    import pba_pkg::*;
#(
    parameter int ARB_CYC     = 3,
    parameter int ARB_EXT_CYC = 6,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] req,
    input  pick_t              pick,
    input  logic               refresh_req,
    input  logic               nmi_req,
    input  logic               xfer_done,
    input  logic               force_arb,
    input  logic               ext_arb,
    output pba_state_e         state,
    output logic [LVL_W-1:0]   owner,
    output logic               set_to,
    output logic               set_nmi_mask,
    output logic               cap_en,
    output logic               preempt
);
    localparam int ACW = $clog2(ARB_EXT_CYC + 1);
    localparam int GCW = $clog2(TIMEOUT_CYC + 1);

    logic [ACW-1:0] arb_cnt;
    logic [GCW-1:0] gnt_cnt;
    logic [ACW-1:0] arb_limit;
    logic           arb_done;
    logic           gnt_expire;

    assign arb_limit  = ext_arb ? ACW'(ARB_EXT_CYC - 1) : ACW'(ARB_CYC - 1);
    assign arb_done   = (arb_cnt >= arb_limit);
    assign gnt_expire = (gnt_cnt == GCW'(TIMEOUT_CYC - 1));

    assign set_nmi_mask = (state == ST_ARB) && arb_done && !refresh_req && nmi_req;
    assign cap_en       = (state == ST_ARB) && arb_done && !refresh_req && !nmi_req
                          && !force_arb && pick.valid;
    assign set_to       = (state == ST_GRANT) && !xfer_done && gnt_expire;
    assign preempt      = (state == ST_GRANT) &&
                          (refresh_req || nmi_req || (|(req & below_mask(owner))));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_ARB;
            arb_cnt <= '0;
            gnt_cnt <= '0;
            owner   <= '0;
        end else begin
            unique case (state)
                ST_ARB: begin
                    if (!arb_done) begin
                        arb_cnt <= arb_cnt + 1'b1;
                    end else if (refresh_req) begin
                        state <= ST_REFRESH;
                    end else if (nmi_req) begin
                        state <= ST_NMI;
                    end else if (cap_en) begin
                        state   <= ST_GRANT;
                        owner   <= pick.level;
                        gnt_cnt <= '0;
                    end
                end
                ST_REFRESH: begin
                    if (xfer_done) begin
                        state   <= ST_ARB;
                        arb_cnt <= '0;
                    end
                end
                ST_NMI: begin
                    if (!nmi_req) begin
                        state   <= ST_ARB;
                        arb_cnt <= '0;
                    end
                end
                ST_GRANT: begin
                    if (xfer_done || gnt_expire) begin
                        state   <= ST_ARB;
                        arb_cnt <= '0;
                    end else begin
                        gnt_cnt <= gnt_cnt + 1'b1;
                    end
                end
                default: state <= ST_ARB;
            endcase
        end
    end

    // R4: NMI service persists while the request stays high
    p_nmi_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NMI && nmi_req) |=> (state == ST_NMI));

    // R5: a channel owner is not dropped while it keeps the transfer open and time remains
    p_grant_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GRANT && !xfer_done && !gnt_expire) |=> (state == ST_GRANT));

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
    import pba_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 100,
    parameter int ARB_MIN_NS    = 300,
    parameter int ARB_EXT_NS    = 600,
    parameter int TIMEOUT_CYC   = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] req,
    input  logic        refresh_req,
    input  logic        nmi_req,
    input  logic        xfer_done,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        arb_state,
    output logic        grant_valid,
    output logic [3:0]  grant_level,
    output logic        grant_refresh,
    output logic        grant_nmi,
    output logic        preempt,
    output logic        cpu_cyc_en
);
    localparam int ARB_CYC     = (ARB_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int ARB_EXT_CYC = (ARB_EXT_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

    pick_t            pick;
    cfg_t             cfg;
    pba_state_e       state;
    logic [LVL_W-1:0] owner;
    logic             set_to;
    logic             set_nmi_mask;
    logic             cap_en;

    pba_resolve u_resolve (
        .req  (req),
        .pick (pick)
    );

    pba_seq #(
        .ARB_CYC     (ARB_CYC),
        .ARB_EXT_CYC (ARB_EXT_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .pick         (pick),
        .refresh_req  (refresh_req),
        .nmi_req      (nmi_req),
        .xfer_done    (xfer_done),
        .force_arb    (cfg.force_arb),
        .ext_arb      (cfg.ext_arb),
        .state        (state),
        .owner        (owner),
        .set_to       (set_to),
        .set_nmi_mask (set_nmi_mask),
        .cap_en       (cap_en),
        .preempt      (preempt)
    );

    pba_cfg u_cfg (
        .clk          (clk),
        .rst          (rst),
        .wr           (reg_wr),
        .rd           (reg_rd),
        .wdata        (reg_wdata),
        .set_to       (set_to),
        .set_nmi_mask (set_nmi_mask),
        .cap_en       (cap_en),
        .cap_level    (owner_next()),
        .cfg          (cfg),
        .rdata        (reg_rdata)
    );

    function automatic logic [LVL_W-1:0] owner_next();
        return pick.level;
    endfunction

    assign arb_state     = (state != ST_GRANT);
    assign grant_valid   = (state == ST_GRANT);
    assign grant_level   = owner;
    assign grant_refresh = (state == ST_REFRESH);
    assign grant_nmi     = (state == ST_NMI);
    assign cpu_cyc_en    = cfg.cpu_en;

    // R1: a new channel owner had no more urgent level requesting when chosen
    p_lowest_wins_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_valid) |-> (($past(req) & below_mask(grant_level)) == '0));

    // R2: a pending refresh is never passed over for NMI
    p_refresh_first_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_nmi) |-> !$past(refresh_req));

    // R2: at most one kind of owner at a time
    p_one_owner_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({grant_valid, grant_refresh, grant_nmi}));

    // R5: preempt only appears while a channel holds the grant
    p_preempt_in_grant_r5: assert property (@(posedge clk) disable iff (rst)
        preempt |-> (grant_valid && !arb_state));

endmodule

// File: tb/prio_bus_arbiter_tb_top.sv
module prio_bus_arbiter_tb_top;

    localparam int TO_CYC = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req = '0;
    logic        refresh_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic        xfer_done = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        arb_state;
    logic        grant_valid;
    logic [3:0]  grant_level;
    logic        grant_refresh;
    logic        grant_nmi;
    logic        preempt;
    logic        cpu_cyc_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    prio_bus_arbiter #(.TIMEOUT_CYC(TO_CYC)) dut_i (
        .clk(clk), .rst(rst), .req(req), .refresh_req(refresh_req),
        .nmi_req(nmi_req), .xfer_done(xfer_done), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .arb_state(arb_state), .grant_valid(grant_valid),
        .grant_level(grant_level), .grant_refresh(grant_refresh),
        .grant_nmi(grant_nmi), .preempt(preempt), .cpu_cyc_en(cpu_cyc_en)
    );

    // {req, ext, expected level}
    localparam logic [20:0] VEC [0:5] = '{
        {16'h0020, 1'b0, 4'd5},
        {16'h8000, 1'b1, 4'd15},
        {16'h8421, 1'b1, 4'd0},
        {16'h0A00, 1'b0, 4'd9},
        {16'hF000, 1'b1, 4'd12},
        {16'h0006, 1'b0, 4'd1}
    };

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] d);
        reg_wdata = d;
        reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic end_xfer();
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R8: reset state
        chk("R8 reset rdata", reg_rdata, 8'h00);
        chk("R8 reset arb_state", arb_state, 1);
        chk("R8 reset no grant", grant_valid, 0);
        chk("R6 reset cpu_cyc_en", cpu_cyc_en, 0);

        // R3: idle stays in arbitrate
        tick(10);
        chk("R3 idle arb_state", arb_state, 1);
        chk("R3 idle no grant", grant_valid, 0);

        // Get a first owner
        req = 16'h8000;
        tick(1);
        chk("R1 first owner valid", grant_valid, 1);
        chk("R1 first owner level", grant_level, 15);

        // Table walk: R1 priority, R3 phase length, R8 captured level
        for (int v = 0; v < 6; v++) begin
            int lim;
            wr_reg({2'b00, VEC[v][4], 5'b0});
            lim = VEC[v][4] ? 6 : 3;
            req = VEC[v][20:5];
            end_xfer();
            tick(lim - 1);
            chk("R3 still arbitrating", arb_state, 1);
            tick();
            chk("R3 grant after phase", grant_valid, 1);
            chk("R1 winning level", grant_level, VEC[v][3:0]);
            chk("R8 last level readback", reg_rdata[3:0], VEC[v][3:0]);
            chk("R8 bit4 zero", reg_rdata[4], 0);
        end

        // R5: preempt with owner level 1
        chk("R5 no preempt baseline", preempt, 0);
        req = 16'h0207;
        #1 chk("R5 preempt by level 0", preempt, 1);
        req = 16'h0206;
        #1 chk("R5 no preempt by higher level", preempt, 0);
        refresh_req = 1'b1;
        #1 chk("R5 preempt by refresh", preempt, 1);
        refresh_req = 1'b0;
        nmi_req = 1'b1;
        #1 chk("R5 preempt by nmi", preempt, 1);
        nmi_req = 1'b0;

        // R7: time-out of a stalled grant
        req = 16'h0010;
        end_xfer();
        tick(3);
        chk("R7 owner level 4", grant_level, 4);
        req = '0;
        tick(TO_CYC - 1);
        chk("R7 grant before limit", grant_valid, 1);
        tick();
        chk("R7 grant ended", grant_valid, 0);
        chk("R7 timeout bit", reg_rdata[5], 1);

        // R2: refresh beats NMI, served in arbitrate
        refresh_req = 1'b1;
        nmi_req = 1'b1;
        tick(5);
        chk("R2 refresh served", grant_refresh, 1);
        chk("R2 refresh in arbitrate", arb_state, 1);
        chk("R2 no nmi yet", grant_nmi, 0);
        refresh_req = 1'b0;
        end_xfer();
        tick(3);
        chk("R2 nmi after refresh", grant_nmi, 1);
        tick(5);
        chk("R4 nmi held", grant_nmi, 1);
        chk("R4 nmi arb_state", arb_state, 1);
        chk("R4 nmi mask + timeout read", reg_rdata, 8'h64);
        reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
        chk("R7 read clears bits 5 and 6", reg_rdata, 8'h04);
        nmi_req = 1'b0;
        tick();
        chk("R4 nmi released", grant_nmi, 0);

        // R7: read without time-out keeps the NMI mask bit
        nmi_req = 1'b1;
        tick(5);
        reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
        chk("R7 mask kept on plain read", reg_rdata, 8'h44);
        nmi_req = 1'b0;
        tick();

        // R6: forced arbitrate and cpu enable
        wr_reg(8'hC0);
        chk("R6 cpu_cyc_en", cpu_cyc_en, 1);
        chk("R6 bit7 readback", reg_rdata[7], 1);
        req = 16'h0008;
        tick(10);
        chk("R6 forced arbitrate", arb_state, 1);
        chk("R6 forced no grant", grant_valid, 0);
        chk("R5 no preempt in arbitrate", preempt, 0);
        wr_reg(8'h80);
        tick();
        chk("R6 grant after release", grant_valid, 1);
        chk("R6 released owner level", grant_level, 3);

        finish_run();
    end

endmodule